// File: doc/BRIEF.md
# PCI Configuration Space Target

This block answers PCI configuration cycles and ignores every other bus command. In an address phase, which is the first clock with FRAME# low after the bus was idle, it looks at IDSEL, the command on C/BE# and the address on AD. If the cycle is a type 0 configuration read or write to its own function, it claims the cycle with DEVSEL#. After a fixed number of wait clocks it asserts TRDY#. It then completes exactly one data phase and returns to idle.

The configuration space has a fixed identification dword, a fixed class dword, a small command field, and one memory base address register whose low bits are hard-wired to zero to size a decode window. Reads of dwords that are not implemented return zero. Writes to them are dropped. For writes, the active-low byte enables on C/BE# during the data phase pick which bytes are updated. The AD bus is split into an input, an output and an output enable, so the pad ring can build the tri-state driver. STOP# is never asserted.

Top module: `pcfg_target`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and STOP# are high, the AD output enable is low, and the base address register (dword 4) reads 0x00000000.
- R2: A cycle is claimed only if, at the first clock edge of FRAME# low after an idle clock, all of these hold: IDSEL is high; C/BE# is 1010 (read) or 1011 (write); AD[10:8] is 000 (function 0); AD[1:0] is 00. AD[7:2] gives the dword number. Any other cycle leaves DEVSEL# high.
- R3: DEVSEL# goes low the clock after the claimed address edge. TRDY# goes low two clocks after that. TRDY# is never low while DEVSEL# is high.
- R4: AD is driven only on reads and only while TRDY# is low. It is never driven in the clock right after the address phase, and never on writes.
- R5: Dword 0 reads 0x0981104A and dword 2 reads 0x02000000. Writes to either of them change nothing.
- R6: The data phase completes only on a clock edge where IRDY# and TRDY# are both low. While IRDY# is high, TRDY#, DEVSEL# and the read data hold. On the clock after completion, DEVSEL# and TRDY# go high and AD is released.
- R7: In dword 4 (the base address register), bits 31:7 are writable and bits 6:0 always read 0. Writing 0xFFFFFFFF reads back 0xFFFFFF80.
- R8: On a write, C/BE#[n] low lets byte n (bits 8n+7:8n) update. C/BE# = 1111 changes nothing.
- R9: In dword 1, only bits 2:0 are writable. All other bits of dword 1 read 0.
- R10: Dwords other than 0, 1, 2 and 4 read 0x00000000, and writes to them have no effect.
- R11: STOP# stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | 32 | AD bus as seen at the pins |
| ad_o | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Enable for the AD output driver |
| cbe_n | input | 4 | Command in the address phase, byte enables in the data phase |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| idsel | input | 1 | Configuration select for this device |
| devsel_n | output | 1 | DEVSEL#, claims the cycle |
| trdy_n | output | 1 | TRDY#, target ready |
| stop_n | output | 1 | STOP#, held high |

## Verification
Every output comes from a register, so each result is due a fixed number of clock edges after the stimulus that causes it. DEVSEL# is due one edge after the address edge. TRDY# and the read data are due three edges after it. The release is due one edge after the first edge where IRDY# and TRDY# are both low. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so it counts whole clocks from the address phase and checks each signal in the exact clock it is due. That includes the clock between DEVSEL# and TRDY# that must show no drive on AD, and every clock of an IRDY# wait. A write is confirmed by reading the same dword back in a later transaction.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam logic [5:0] DW_IDENT = 6'd0;
    localparam logic [5:0] DW_CMD   = 6'd1;
    localparam logic [5:0] DW_CLASS = 6'd2;
    localparam logic [5:0] DW_BAR   = 6'd4;

    typedef enum logic [1:0] {
        TS_IDLE,
        TS_WAIT,
        TS_DATA
    } tgt_state_e;

    typedef struct packed {
        logic       hit;
        logic       wr;
        logic [5:0] dw;
    } cfg_hit_t;

endpackage

// File: rtl/pcfg_addr_decode.sv
module pcfg_addr_decode
    import pcfg_pkg::*;
#(
    parameter logic [2:0] FUNC_NUM = 3'd0
) (
    input  logic [31:0] ad,
    input  logic [3:0]  cbe_n,
    input  logic        idsel,
    input  logic        frame_n,
    input  logic        frame_prev,
    input  logic        idle,
    output cfg_hit_t    hit
);

    logic addr_phase;
    logic is_cfg;
    logic type0_own;

    always_comb begin
        // first clock of FRAME# low after an idle clock
        addr_phase = idle && frame_prev && !frame_n;
        is_cfg     = (cbe_n == CMD_CFG_RD) || (cbe_n == CMD_CFG_WR);
        type0_own  = (ad[10:8] == FUNC_NUM) && (ad[1:0] == 2'b00);
        hit.hit    = addr_phase && idsel && is_cfg && type0_own;
        hit.wr     = (cbe_n == CMD_CFG_WR);
        hit.dw     = ad[7:2];
    end

endmodule

// File: rtl/pcfg_regs.sv
module pcfg_regs
    import pcfg_pkg::*;
#(
    parameter logic [31:0] IDENT_WORD  = 32'h0981_104A,
    parameter logic [31:0] CLASS_WORD  = 32'h0200_0000,
    parameter logic [15:0] CMD_WMASK   = 16'h0007,
    parameter int          BAR_WIN_LOG2 = 7,
    parameter int          LANES        = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [5:0]           rd_dw,
    output logic [8*LANES-1:0]   rd_data,
    input  logic                 wr_en,
    input  logic [5:0]           wr_dw,
    input  logic [LANES-1:0]     wr_be_n,
    input  logic [8*LANES-1:0]   wr_data
);

    localparam int          DW_BITS  = 8 * LANES;
    localparam logic [31:0] BAR_MASK = ~((32'd1 << BAR_WIN_LOG2) - 32'd1);

    typedef struct packed {
        logic [15:0]        cmd;
        logic [DW_BITS-1:0] bar;
    } regs_t;

    regs_t              regs_d, regs_q;
    logic [DW_BITS-1:0] lane_mask;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{~wr_be_n[b]}};
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_dw)
                DW_CMD: regs_d.cmd = ((regs_q.cmd & ~lane_mask[15:0]) |
                                      (wr_data[15:0] & lane_mask[15:0])) & CMD_WMASK;
                DW_BAR: regs_d.bar = ((regs_q.bar & ~lane_mask) |
                                      (wr_data & lane_mask)) & BAR_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_dw)
            DW_IDENT: rd_data = IDENT_WORD;
            DW_CMD:   rd_data = {16'h0000, regs_q.cmd};
            DW_CLASS: rd_data = CLASS_WORD;
            DW_BAR:   rd_data = regs_q.bar;
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

endmodule

// File: rtl/pcfg_target.sv
module pcfg_target
    import pcfg_pkg::*;
#(
    parameter int          TRDY_DELAY   = 2,
    parameter logic [2:0]  FUNC_NUM     = 3'd0,
    parameter logic [31:0] IDENT_WORD   = 32'h0981_104A,
    parameter logic [31:0] CLASS_WORD   = 32'h0200_0000,
    parameter int          BAR_WIN_LOG2 = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ad_i,
    output logic [31:0] ad_o,
    output logic        ad_oe,
    input  logic [3:0]  cbe_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        idsel,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n
);

    localparam int CNT_W = $clog2(TRDY_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRDY_DELAY - 1);

    typedef struct packed {
        tgt_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             wr;
        logic [5:0]       dw;
        logic             frame_prev;
        logic             devsel_n;
        logic             trdy_n;
        logic             ad_oe;
        logic [31:0]      ad_o;
    } tgt_t;

    tgt_t     tgt_d, tgt_q;
    cfg_hit_t hit;
    logic [31:0] rd_data;
    logic        wr_en;

    pcfg_addr_decode #(.FUNC_NUM(FUNC_NUM)) u_decode (
        .ad         (ad_i),
        .cbe_n      (cbe_n),
        .idsel      (idsel),
        .frame_n    (frame_n),
        .frame_prev (tgt_q.frame_prev),
        .idle       (tgt_q.state == TS_IDLE),
        .hit        (hit)
    );

    pcfg_regs #(
        .IDENT_WORD   (IDENT_WORD),
        .CLASS_WORD   (CLASS_WORD),
        .BAR_WIN_LOG2 (BAR_WIN_LOG2)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_dw   (tgt_q.dw),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_dw   (tgt_q.dw),
        .wr_be_n (cbe_n),
        .wr_data (ad_i)
    );

    always_comb begin
        tgt_d            = tgt_q;
        tgt_d.frame_prev = frame_n;
        wr_en            = 1'b0;
        case (tgt_q.state)
            TS_IDLE: begin
                if (hit.hit) begin
                    tgt_d.state    = TS_WAIT;
                    tgt_d.cnt      = '0;
                    tgt_d.wr       = hit.wr;
                    tgt_d.dw       = hit.dw;
                    tgt_d.devsel_n = 1'b0;
                end
            end
            TS_WAIT: begin
                if (tgt_q.cnt == CNT_LAST) begin
                    tgt_d.state  = TS_DATA;
                    tgt_d.trdy_n = 1'b0;
                    tgt_d.ad_oe  = !tgt_q.wr;
                    tgt_d.ad_o   = tgt_q.wr ? 32'h0 : rd_data;
                end else begin
                    tgt_d.cnt = tgt_q.cnt + CNT_W'(1);
                end
            end
            TS_DATA: begin
                if (!irdy_n) begin
                    wr_en          = tgt_q.wr;
                    tgt_d.state    = TS_IDLE;
                    tgt_d.devsel_n = 1'b1;
                    tgt_d.trdy_n   = 1'b1;
                    tgt_d.ad_oe    = 1'b0;
                    tgt_d.ad_o     = 32'h0;
                end
            end
            default: tgt_d.state = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q            <= '0;
            tgt_q.state      <= TS_IDLE;
            tgt_q.frame_prev <= 1'b1;
            tgt_q.devsel_n   <= 1'b1;
            tgt_q.trdy_n     <= 1'b1;
        end else begin
            tgt_q <= tgt_d;
        end
    end

    assign ad_o     = tgt_q.ad_o;
    assign ad_oe    = tgt_q.ad_oe;
    assign devsel_n = tgt_q.devsel_n;
    assign trdy_n   = tgt_q.trdy_n;
    assign stop_n   = 1'b1;

    // R3
    trdy_with_devsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    // R3
    devsel_leads_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_n) |-> $past(!devsel_n));

    // R4
    ad_drive_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!trdy_n && !devsel_n));

    // R6
    release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n) |=> (devsel_n && trdy_n && !ad_oe));

    // R6
    hold_on_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |=> (!trdy_n && !devsel_n && $stable(ad_o)));

endmodule

// File: tb/pcfg_target_bench.sv
module pcfg_target_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = 32'h0;
    logic [31:0] ad_o;
    logic        ad_oe;
    logic [3:0]  cbe_n = 4'hF;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        idsel = 1'b0;
    logic        devsel_n;
    logic        trdy_n;
    logic        stop_n;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pcfg_target u_pcfg_target (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [5:0]  dw;
        logic [3:0]  be_n;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd5,  1'b0, 6'd0,  4'h0, 32'h0,        32'h0981104A}, // R5 ident
        '{4'd5,  1'b1, 6'd0,  4'h0, 32'hFFFFFFFF, 32'h0},        // R5 write ignored
        '{4'd5,  1'b0, 6'd0,  4'h0, 32'h0,        32'h0981104A}, // R5
        '{4'd5,  1'b0, 6'd2,  4'h0, 32'h0,        32'h02000000}, // R5 class
        '{4'd7,  1'b1, 6'd4,  4'h0, 32'hFFFFFFFF, 32'h0},        // R7
        '{4'd7,  1'b0, 6'd4,  4'h0, 32'h0,        32'hFFFFFF80}, // R7 low bits zero
        '{4'd8,  1'b1, 6'd4,  4'h3, 32'h12345678, 32'h0},        // R8 bytes 3,2 only
        '{4'd8,  1'b0, 6'd4,  4'h0, 32'h0,        32'h1234FF80}, // R8
        '{4'd9,  1'b1, 6'd1,  4'h0, 32'hFFFFFFFF, 32'h0},        // R9
        '{4'd9,  1'b0, 6'd1,  4'h0, 32'h0,        32'h00000007}, // R9
        '{4'd8,  1'b1, 6'd1,  4'hF, 32'h00000002, 32'h0},        // R8 no lanes
        '{4'd8,  1'b0, 6'd1,  4'h0, 32'h0,        32'h00000007}, // R8
        '{4'd10, 1'b1, 6'd9,  4'h0, 32'hAAAAAAAA, 32'h0}         // R10
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_addr(input logic [2:0] fn, input logic [5:0] dw);
        return {21'h0, fn, dw, 2'b00};
    endfunction

    // one transaction, single data phase; inputs change on falling edges
    task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                       input logic [3:0] be_n, input logic [31:0] wd, input int waits,
                       input bit claim, input string tag, output logic [31:0] rd);
        rd = 32'h0;
        @(negedge clk);
        frame_n = 1'b0; idsel = sel; cbe_n = cmd; ad_i = addr; irdy_n = 1'b1;
        @(negedge clk);
        frame_n = 1'b1; idsel = 1'b0; cbe_n = be_n;
        ad_i = cmd[0] ? wd : 32'h0;
        irdy_n = (waits == 0) ? 1'b0 : 1'b1;
        // R2 R3: claim one clock after address edge
        chk(devsel_n == !claim, {tag, " R2 R3 devsel"}, {31'h0, devsel_n}, {31'h0, !claim});
        chk(trdy_n && !ad_oe, {tag, " R4 turnaround"}, {30'h0, trdy_n, ad_oe}, 32'h2);
        @(negedge clk);
        chk(trdy_n && !ad_oe && devsel_n == !claim, {tag, " R3 wait clock"},
            {30'h0, trdy_n, ad_oe}, 32'h2);
        @(negedge clk);
        if (claim) begin
            chk(!trdy_n && !devsel_n, {tag, " R3 trdy due"}, {30'h0, devsel_n, trdy_n}, 32'h0);
            chk(ad_oe == !cmd[0], {tag, " R4 drive"}, {31'h0, ad_oe}, {31'h0, !cmd[0]});
            rd = ad_o;
            for (int i = 0; i < waits; i++) begin
                @(negedge clk);
                chk(!trdy_n && !devsel_n && ad_o == rd, {tag, " R6 hold"}, ad_o, rd);
            end
            irdy_n = 1'b0;
            @(negedge clk);
            chk(devsel_n && trdy_n && !ad_oe, {tag, " R6 release"},
                {29'h0, devsel_n, trdy_n, ad_oe}, 32'h6);
        end else begin
            @(negedge clk);
            chk(devsel_n && trdy_n && !ad_oe, {tag, " R2 unclaimed"},
                {29'h0, devsel_n, trdy_n, ad_oe}, 32'h6);
        end
        irdy_n = 1'b1; ad_i = 32'h0; cbe_n = 4'hF;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(negedge clk) begin
        if (rst_n && !stop_n) begin
            n_chk++; n_fail++;
            $display("FAIL R11 stop actual=%h expected=%h", stop_n, 1'b1);
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(devsel_n && trdy_n && stop_n && !ad_oe, "R1 reset outputs",
            {28'h0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
        rst_n = 1'b1;
        @(negedge clk);
        txn(4'b1010, cfg_addr(3'd0, 6'd4), 1'b1, 4'h0, 32'h0, 0, 1'b1, "R1 bar reset", rd);
        chk(rd == 32'h0, "R1 bar reset value", rd, 32'h0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            txn(VECS[v].wr ? 4'b1011 : 4'b1010, cfg_addr(3'd0, VECS[v].dw), 1'b1,
                VECS[v].be_n, VECS[v].wd, 0, 1'b1, tag, rd);
            if (!VECS[v].wr) chk(rd == VECS[v].exp, {tag, " data"}, rd, VECS[v].exp);
        end

        // R10 reserved dwords read zero after a write
        txn(4'b1010, cfg_addr(3'd0, 6'd9), 1'b1, 4'h0, 32'h0, 0, 1'b1, "R10 dw9", rd);
        chk(rd == 32'h0, "R10 dw9 data", rd, 32'h0);
        txn(4'b1010, cfg_addr(3'd0, 6'd63), 1'b1, 4'h0, 32'h0, 0, 1'b1, "R10 dw63", rd);
        chk(rd == 32'h0, "R10 dw63 data", rd, 32'h0);

        // R6 initiator wait states on a read
        txn(4'b1010, cfg_addr(3'd0, 6'd0), 1'b1, 4'h0, 32'h0, 3, 1'b1, "R6 wait read", rd);
        chk(rd == 32'h0981104A, "R6 wait read data", rd, 32'h0981104A);
        // R6 wait states on a write, then read back
        txn(4'b1011, cfg_addr(3'd0, 6'd4), 1'b1, 4'h0, 32'h00ABCD00, 2, 1'b1, "R6 wait write", rd);
        txn(4'b1010, cfg_addr(3'd0, 6'd4), 1'b1, 4'h0, 32'h0, 0, 1'b1, "R6 readback", rd);
        chk(rd == 32'h00ABCD00, "R6 write data", rd, 32'h00ABCD00);

        // R2 cycles that must not be claimed
        txn(4'b1011, cfg_addr(3'd0, 6'd4), 1'b0, 4'h0, 32'h11111111, 0, 1'b0, "R2 idsel low", rd);
        txn(4'b1011, cfg_addr(3'd1, 6'd4), 1'b1, 4'h0, 32'h22222222, 0, 1'b0, "R2 function 1", rd);
        txn(4'b0111, cfg_addr(3'd0, 6'd4), 1'b1, 4'h0, 32'h33333333, 0, 1'b0, "R2 mem write", rd);
        txn(4'b1011, cfg_addr(3'd0, 6'd4) | 32'h1, 1'b1, 4'h0, 32'h44444444, 0, 1'b0, "R2 type 1", rd);
        txn(4'b1010, cfg_addr(3'd0, 6'd4), 1'b1, 4'h0, 32'h0, 0, 1'b1, "R2 bar intact", rd);
        chk(rd == 32'h00ABCD00, "R2 no write landed", rd, 32'h00ABCD00);

        // R1 reset clears the base address register
        rst_n = 1'b0;
        @(negedge clk);
        chk(devsel_n && trdy_n && !ad_oe, "R1 in reset", {29'h0, devsel_n, trdy_n, ad_oe}, 32'h6);
        rst_n = 1'b1;
        @(negedge clk);
        txn(4'b1010, cfg_addr(3'd0, 6'd4), 1'b1, 4'h0, 32'h0, 0, 1'b1, "R1 after reset", rd);
        chk(rd == 32'h0, "R1 bar cleared", rd, 32'h0);
        chk(stop_n, "R11 stop high", {31'h0, stop_n}, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule